// File: doc/BRIEF.md
# Progressive-Scan CCD Timing Generator

This block generates every logic-level drive and framing signal that a progressive-scan interline CCD with a VGA-class pixel array needs. It runs from one clock at twice the pixel rate, so each pixel period has two clock phases. From that clock it produces line and frame sync and a pair of complementary horizontal shift clocks. It also produces a reset-gate pulse, four vertical shift phases, two charge-transfer pulses on the frame readout line and an overflow-drain pulse that acts as the electronic shutter. Analog drive levels are generated outside the block.

For each clock the block also says what the sensor output carries at that moment. A valid flag marks clocks on which the horizontal register is shifting. A zone code marks the sample as dummy, optical black or effective. A colour code gives the mosaic colour of effective sites, so that later stages can clamp black level and demosaic without their own counters. A shutter-line input sets the exposure. It is sampled only at the start of a frame, so a write in the middle of a frame cannot tear the exposure.

The line length, frame height, zone sizes and edge positions are all parameters. The defaults give 780 pixels per line and 525 lines per frame.

Top module: `ccd_tgen`

## Requirements
- R1: A line lasts LINE_PIX pixel periods of two clocks each. `hd` is high for the first HSYNC_W pixels of every line and low elsewhere, so successive rising edges of `hd` are 2·LINE_PIX clocks apart.
- R2: A frame lasts FRAME_LINES lines. Line 0 is the readout line and `vd` is high for all of it and for no other line.
- R3: For pixel positions 38 to 106 of each line (the idle window), `h1`=1, `h2`=0 and `rg`=0. At every other position `h1` is high on the first clock of each pixel and low on the second, `h2` is its complement, and `rg` is high exactly when `h1` is high.
- R4: Outside the idle window, `samp_valid`=1. Sample index s counts from position 107 (s=0) and wraps through the end of the line into the next line up to position 37 (s=710). Horizontally, s 0–15 is dummy, 16–17 optical black, 18–676 effective and 677–710 optical black. Zone codes: 0 none, 1 dummy, 2 optical black, 3 effective. Inside the idle window `samp_valid`=0 and the zone code is 0.
- R5: A sample belongs to line L when emitted at position ≥38 of L, and to line L−1 (line FRAME_LINES−1 after line 0) when emitted before position 38. Line L≥1 carries row L−1. Rows 0..V_DUMMY−1 are dummy, the next V_OBF rows are optical black, the next V_EFF rows are effective and the next V_OBR rows are optical black. Line 0 and lines past the last row give zone 0. Dummy takes priority over optical black, which takes priority over effective.
- R6: `samp_color` is 0 unless the zone is effective. With e the effective row and c the effective column (both from 0), even e gives G (2) at even c and B (3) at odd c. Odd e gives R (1) at even c and G (2) at odd c.
- R7: On lines 1 and above, {v1,v2,v3,v4} is 1100 before position 38. It then moves through 1110, 0110, 0111, 0011, 1011, 1001 and 1101, changing at positions 38, 45, 52, 59, 66, 73 and 80, and returns to 1100 at position 87.
- R8: On line 0, the vertical phases stay at 1100. `tg1` is high for positions 276–337 and `tg3` for positions 319–380. Both transfer pulses are low on every other line.
- R9: `ofd` is high for positions 94–100 on lines L with 1 ≤ L < latched shutter line, and low at all other times.
- R10: The shutter line is latched during reset and on the clock that starts line 0. Changing `shutter_line` at any other time has no effect on `ofd` until the next frame starts.
- R11: The vertical phases change only inside the idle window, never while `samp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| shutter_line | input | $clog2(FRAME_LINES) | Last line + 1 that still gets an overflow-drain pulse |
| hd | output | 1 | Line sync |
| vd | output | 1 | Frame sync (readout line) |
| h1 | output | 1 | Horizontal shift phase 1 |
| h2 | output | 1 | Horizontal shift phase 2 |
| rg | output | 1 | Reset-gate pulse |
| v1 | output | 1 | Vertical shift phase 1 |
| v2 | output | 1 | Vertical shift phase 2 |
| v3 | output | 1 | Vertical shift phase 3 |
| v4 | output | 1 | Vertical shift phase 4 |
| tg1 | output | 1 | Charge-transfer pulse on phase 1 |
| tg3 | output | 1 | Charge-transfer pulse on phase 3 |
| ofd | output | 1 | Overflow-drain shutter pulse |
| samp_valid | output | 1 | Horizontal register is shifting a sample |
| samp_zone | output | 2 | Sample zone code |
| samp_color | output | 2 | Mosaic colour of an effective sample |

## Verification
The assertions check the relations that must hold on every clock:
- the two horizontal phases are always complementary, and the reset gate is only high while `h1` is high;
- the vertical phases never move outside the idle window;
- the transfer pulses appear only on the readout line;
- the shutter pulse stays inside blanking;
- the latched shutter line holds between frame starts;
- a colour is reported exactly when the zone is effective.

Only the bench scenarios can show the exact zone sizes per row, the wrap of a row's samples into the next line, the mosaic phase and the line and frame periods. They can also show that a shutter-line change in mid-frame takes effect one frame later, including the edge cases of no pulses (0 and 1) and pulses on every line except the last.

// File: rtl/ccd_tgen_pkg.sv
package ccd_tgen_pkg;

    typedef enum logic [1:0] {
        ZN_NONE  = 2'd0,
        ZN_DUMMY = 2'd1,
        ZN_OB    = 2'd2,
        ZN_EFF   = 2'd3
    } zone_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_R    = 2'd1,
        CL_G    = 2'd2,
        CL_B    = 2'd3
    } color_e;

    typedef struct packed {
        logic v1;
        logic v2;
        logic v3;
        logic v4;
    } vclk_t;

    // vertical phase state after k staggered edges of a shift line
    function automatic vclk_t vstep_pattern(input logic [3:0] k);
        vclk_t p;
        case (k)
            4'd1:    p = '{v1: 1'b1, v2: 1'b1, v3: 1'b1, v4: 1'b0};
            4'd2:    p = '{v1: 1'b0, v2: 1'b1, v3: 1'b1, v4: 1'b0};
            4'd3:    p = '{v1: 1'b0, v2: 1'b1, v3: 1'b1, v4: 1'b1};
            4'd4:    p = '{v1: 1'b0, v2: 1'b0, v3: 1'b1, v4: 1'b1};
            4'd5:    p = '{v1: 1'b1, v2: 1'b0, v3: 1'b1, v4: 1'b1};
            4'd6:    p = '{v1: 1'b1, v2: 1'b0, v3: 1'b0, v4: 1'b1};
            4'd7:    p = '{v1: 1'b1, v2: 1'b1, v3: 1'b0, v4: 1'b1};
            default: p = '{v1: 1'b1, v2: 1'b1, v3: 1'b0, v4: 1'b0};
        endcase
        return p;
    endfunction

    // classify an index against four consecutive spans: pre, front, main, rear
    function automatic zone_e span_zone(input int idx, input int n_pre,
                                        input int n_front, input int n_main,
                                        input int n_rear);
        zone_e z;
        if (idx < 0)                                   z = ZN_NONE;
        else if (idx < n_pre)                          z = ZN_DUMMY;
        else if (idx < n_pre + n_front)                z = ZN_OB;
        else if (idx < n_pre + n_front + n_main)       z = ZN_EFF;
        else if (idx < n_pre + n_front + n_main + n_rear) z = ZN_OB;
        else                                           z = ZN_NONE;
        return z;
    endfunction

    // combine vertical and horizontal classification, dummy before black
    function automatic zone_e merge_zone(input zone_e vz, input zone_e hz);
        zone_e z;
        if (vz == ZN_NONE || hz == ZN_NONE)        z = ZN_NONE;
        else if (vz == ZN_DUMMY || hz == ZN_DUMMY) z = ZN_DUMMY;
        else if (vz == ZN_OB || hz == ZN_OB)       z = ZN_OB;
        else                                       z = ZN_EFF;
        return z;
    endfunction

    function automatic color_e mosaic_site(input logic row_odd, input logic col_odd);
        color_e c;
        if (row_odd) c = col_odd ? CL_G : CL_R;
        else         c = col_odd ? CL_B : CL_G;
        return c;
    endfunction

endpackage

// File: rtl/ccd_tgen_timebase.sv
module ccd_tgen_timebase #(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525
) (
    input  logic                           clk,
    input  logic                           rst,
    output logic                           ph,
    output logic [$clog2(LINE_PIX)-1:0]    hc,
    output logic [$clog2(FRAME_LINES)-1:0] ln,
    output logic                           frame_wrap
);
    localparam int HC_W = $clog2(LINE_PIX);
    localparam int LN_W = $clog2(FRAME_LINES);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(LINE_PIX - 1);
    localparam logic [LN_W-1:0] LN_LAST = LN_W'(FRAME_LINES - 1);

    logic line_wrap;

    assign line_wrap  = ph && (hc == HC_LAST);
    assign frame_wrap = line_wrap && (ln == LN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= 1'b0;
            hc <= '0;
            ln <= '0;
        end else begin
            ph <= ~ph;
            if (ph) begin
                if (line_wrap) begin
                    hc <= '0;
                    ln <= (ln == LN_LAST) ? '0 : ln + 1'b1;
                end else begin
                    hc <= hc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ccd_tgen_shutter.sv
module ccd_tgen_shutter #(
    parameter int FRAME_LINES = 525
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           frame_wrap,
    input  logic [$clog2(FRAME_LINES)-1:0] shutter_line,
    output logic [$clog2(FRAME_LINES)-1:0] sh
);
    always_ff @(posedge clk) begin
        if (rst || frame_wrap) sh <= shutter_line;
    end
endmodule

// File: rtl/ccd_tgen_vdrive.sv
module ccd_tgen_vdrive
    import ccd_tgen_pkg::*;
#(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int V_EDGE0     = 38,
    parameter int V_STEP      = 7,
    parameter int V_EDGES     = 8,
    parameter int OFD_START   = 94,
    parameter int OFD_LEN     = 7,
    parameter int TGA_START   = 276,
    parameter int TGB_START   = 319,
    parameter int TG_LEN      = 62
) (
    input  logic [$clog2(LINE_PIX)-1:0]    hc,
    input  logic [$clog2(FRAME_LINES)-1:0] ln,
    input  logic [$clog2(FRAME_LINES)-1:0] sh,
    output vclk_t                          vc,
    output logic                           tg1,
    output logic                           tg3,
    output logic                           ofd
);
    logic [V_EDGES-1:0] passed;
    logic [3:0]         k;
    logic               readout;
    int                 hci;

    assign hci     = int'(hc);
    assign readout = (ln == '0);

    // one comparator per staggered edge position
    for (genvar i = 0; i < V_EDGES; i++) begin : g_edge
        assign passed[i] = (hci >= V_EDGE0 + i * V_STEP);
    end

    always_comb begin
        k = '0;
        for (int i = 0; i < V_EDGES; i++) k = k + {3'b000, passed[i]};
    end

    always_comb begin
        vc  = readout ? vstep_pattern(4'd0) : vstep_pattern(k);
        tg1 = readout && (hci >= TGA_START) && (hci < TGA_START + TG_LEN);
        tg3 = readout && (hci >= TGB_START) && (hci < TGB_START + TG_LEN);
        ofd = !readout && (ln < sh) && (hci >= OFD_START) && (hci < OFD_START + OFD_LEN);
    end
endmodule

// File: rtl/ccd_tgen_tagger.sv
module ccd_tgen_tagger
    import ccd_tgen_pkg::*;
#(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int IDLE_START  = 38,
    parameter int IDLE_END    = 107,
    parameter int H_DUMMY     = 16,
    parameter int H_OBF       = 2,
    parameter int H_EFF       = 659,
    parameter int H_OBR       = 34,
    parameter int V_DUMMY     = 4,
    parameter int V_OBF       = 8,
    parameter int V_EFF       = 494,
    parameter int V_OBR       = 2
) (
    input  logic [$clog2(LINE_PIX)-1:0]    hc,
    input  logic [$clog2(FRAME_LINES)-1:0] ln,
    output logic                           valid,
    output zone_e                          zone,
    output color_e                         color
);
    int hci, lni, sidx, sline, row, erow, ecol;
    zone_e hz, vz;

    always_comb begin
        hci   = int'(hc);
        lni   = int'(ln);
        valid = !((hci >= IDLE_START) && (hci < IDLE_END));
        sidx  = (hci >= IDLE_END) ? hci - IDLE_END : hci + LINE_PIX - IDLE_END;
        if (hci < IDLE_START) sline = (lni == 0) ? FRAME_LINES - 1 : lni - 1;
        else                  sline = lni;
        row   = sline - 1;
        hz    = span_zone(sidx, H_DUMMY, H_OBF, H_EFF, H_OBR);
        vz    = span_zone(row, V_DUMMY, V_OBF, V_EFF, V_OBR);
        zone  = valid ? merge_zone(vz, hz) : ZN_NONE;
        erow  = row - V_DUMMY - V_OBF;
        ecol  = sidx - H_DUMMY - H_OBF;
        color = (zone == ZN_EFF) ? mosaic_site(erow[0], ecol[0]) : CL_NONE;
    end
endmodule

// File: rtl/ccd_tgen.sv
module ccd_tgen
    import ccd_tgen_pkg::*;
#(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int HSYNC_W     = 32,
    parameter int IDLE_START  = 38,
    parameter int IDLE_END    = 107,
    parameter int H_DUMMY     = 16,
    parameter int H_OBF       = 2,
    parameter int H_EFF       = 659,
    parameter int H_OBR       = 34,
    parameter int V_DUMMY     = 4,
    parameter int V_OBF       = 8,
    parameter int V_EFF       = 494,
    parameter int V_OBR       = 2,
    parameter int V_STEP      = 7,
    parameter int OFD_START   = 94,
    parameter int OFD_LEN     = 7,
    parameter int TGA_START   = 276,
    parameter int TGB_START   = 319,
    parameter int TG_LEN      = 62
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [$clog2(FRAME_LINES)-1:0] shutter_line,
    output logic                           hd,
    output logic                           vd,
    output logic                           h1,
    output logic                           h2,
    output logic                           rg,
    output logic                           v1,
    output logic                           v2,
    output logic                           v3,
    output logic                           v4,
    output logic                           tg1,
    output logic                           tg3,
    output logic                           ofd,
    output logic                           samp_valid,
    output logic [1:0]                     samp_zone,
    output logic [1:0]                     samp_color
);
    localparam int HC_W = $clog2(LINE_PIX);
    localparam int LN_W = $clog2(FRAME_LINES);

    logic            ph_q;
    logic [HC_W-1:0] hc_q;
    logic [LN_W-1:0] ln_q;
    logic [LN_W-1:0] sh_q;
    logic            frame_wrap;
    vclk_t           vc;
    zone_e           zone;
    color_e          color;

    ccd_tgen_timebase #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_tb (
        .clk(clk), .rst(rst), .ph(ph_q), .hc(hc_q), .ln(ln_q), .frame_wrap(frame_wrap)
    );

    ccd_tgen_shutter #(.FRAME_LINES(FRAME_LINES)) u_sh (
        .clk(clk), .rst(rst), .frame_wrap(frame_wrap),
        .shutter_line(shutter_line), .sh(sh_q)
    );

    ccd_tgen_vdrive #(
        .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .V_EDGE0(IDLE_START),
        .V_STEP(V_STEP), .V_EDGES(8), .OFD_START(OFD_START), .OFD_LEN(OFD_LEN),
        .TGA_START(TGA_START), .TGB_START(TGB_START), .TG_LEN(TG_LEN)
    ) u_vd (
        .hc(hc_q), .ln(ln_q), .sh(sh_q), .vc(vc), .tg1(tg1), .tg3(tg3), .ofd(ofd)
    );

    ccd_tgen_tagger #(
        .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .IDLE_START(IDLE_START),
        .IDLE_END(IDLE_END), .H_DUMMY(H_DUMMY), .H_OBF(H_OBF), .H_EFF(H_EFF),
        .H_OBR(H_OBR), .V_DUMMY(V_DUMMY), .V_OBF(V_OBF), .V_EFF(V_EFF), .V_OBR(V_OBR)
    ) u_tag (
        .hc(hc_q), .ln(ln_q), .valid(samp_valid), .zone(zone), .color(color)
    );

    always_comb begin
        hd = (int'(hc_q) < HSYNC_W);
        vd = (ln_q == '0);
        // horizontal register parked during the idle window
        h1 = samp_valid ? ~ph_q : 1'b1;
        h2 = samp_valid ?  ph_q : 1'b0;
        rg = samp_valid & ~ph_q;
        {v1, v2, v3, v4} = vc;
        samp_zone  = zone;
        samp_color = color;
    end
endmodule

// File: rtl/ccd_tgen_chk.sv
module ccd_tgen_chk #(
    parameter int LINE_PIX    = 780,
    parameter int FRAME_LINES = 525,
    parameter int IDLE_START  = 38,
    parameter int IDLE_END    = 107
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           ph,
    input logic [$clog2(LINE_PIX)-1:0]    hc,
    input logic [$clog2(FRAME_LINES)-1:0] ln,
    input logic [$clog2(FRAME_LINES)-1:0] sh,
    input logic                           vd,
    input logic                           h1,
    input logic                           h2,
    input logic                           rg,
    input logic [3:0]                     vph,
    input logic                           tg1,
    input logic                           tg3,
    input logic                           ofd,
    input logic                           samp_valid,
    input logic [1:0]                     samp_zone,
    input logic [1:0]                     samp_color
);
    logic in_idle, frame_step;
    assign in_idle    = (int'(hc) >= IDLE_START) && (int'(hc) < IDLE_END);
    assign frame_step = ph && (int'(hc) == LINE_PIX - 1) && (int'(ln) == FRAME_LINES - 1);

    a_r1_phase_toggle: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ph != $past(ph)));
    a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
        (ph && int'(hc) == LINE_PIX - 1) |=> (hc == '0));
    a_r2_vd_at_frame: assert property (@(posedge clk) disable iff (rst)
        frame_step |=> vd);
    a_r3_h_complement: assert property (@(posedge clk) disable iff (rst)
        h1 != h2);
    a_r3_rg_in_h1: assert property (@(posedge clk) disable iff (rst)
        rg |-> h1);
    a_r4_idle_no_zone: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |-> (samp_zone == 2'd0));
    a_r6_color_iff_eff: assert property (@(posedge clk) disable iff (rst)
        (samp_color != 2'd0) == (samp_zone == 2'd3));
    a_r8_tg_readout_only: assert property (@(posedge clk) disable iff (rst)
        (tg1 || tg3) |-> (ln == '0));
    a_r9_ofd_blank: assert property (@(posedge clk) disable iff (rst)
        ofd |-> (in_idle && ln != '0 && ln < sh));
    a_r10_shutter_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_step |=> $stable(sh));
    a_r11_v_in_idle: assert property (@(posedge clk) disable iff (rst)
        !$stable(vph) |-> (in_idle && !samp_valid));
endmodule

bind ccd_tgen ccd_tgen_chk #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES),
    .IDLE_START(IDLE_START), .IDLE_END(IDLE_END)
) u_chk (
    .clk(clk), .rst(rst), .ph(ph_q), .hc(hc_q), .ln(ln_q), .sh(sh_q), .vd(vd),
    .h1(h1), .h2(h2), .rg(rg), .vph({v1, v2, v3, v4}), .tg1(tg1), .tg3(tg3),
    .ofd(ofd), .samp_valid(samp_valid), .samp_zone(samp_zone), .samp_color(samp_color)
);

// File: tb/ccd_tgen_tb.sv
module ccd_tgen_tb;
    localparam int LP = 780, FL = 16, HSW = 32;
    localparam int VDM = 2, VOF = 2, VEF = 6, VOR = 2;
    localparam int HDM = 16, HOF = 2, HEF = 659, HOR = 34;
    localparam int IS = 38, IE = 107;
    localparam int CL = 2 * LP;
    localparam int NFRAMES = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic [3:0] shutter_line;
    logic hd, vd, h1, h2, rg, v1, v2, v3, v4, tg1, tg3, ofd, samp_valid;
    logic [1:0] samp_zone, samp_color;

    ccd_tgen #(.LINE_PIX(LP), .FRAME_LINES(FL), .HSYNC_W(HSW),
               .V_DUMMY(VDM), .V_OBF(VOF), .V_EFF(VEF), .V_OBR(VOR)) u_dut (
        .clk(clk), .rst(rst), .shutter_line(shutter_line), .hd(hd), .vd(vd),
        .h1(h1), .h2(h2), .rg(rg), .v1(v1), .v2(v2), .v3(v3), .v4(v4),
        .tg1(tg1), .tg3(tg3), .ofd(ofd), .samp_valid(samp_valid),
        .samp_zone(samp_zone), .samp_color(samp_color)
    );

    int  n_checks = 0, n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int span(input int idx, input int a, input int b, input int c, input int d);
        if (idx < 0)                 return 0;
        if (idx < a)                 return 1;
        if (idx < a + b)             return 2;
        if (idx < a + b + c)         return 3;
        if (idx < a + b + c + d)     return 2;
        return 0;
    endfunction

    function automatic bit idle(input int hc);
        return (hc >= IS) && (hc < IE);
    endfunction

    function automatic int sidx(input int hc);
        return (hc >= IE) ? hc - IE : hc + LP - IE;
    endfunction

    function automatic int srow(input int hc, input int ln);
        int sl;
        sl = (hc < IS) ? ((ln == 0) ? FL - 1 : ln - 1) : ln;
        return sl - 1;
    endfunction

    function automatic int exp_zone(input int hc, input int ln);
        int vz, hz;
        if (idle(hc)) return 0;
        vz = span(srow(hc, ln), VDM, VOF, VEF, VOR);
        hz = span(sidx(hc), HDM, HOF, HEF, HOR);
        if (vz == 0 || hz == 0) return 0;
        if (vz == 1 || hz == 1) return 1;
        if (vz == 2 || hz == 2) return 2;
        return 3;
    endfunction

    function automatic int exp_color(input int hc, input int ln);
        int e, c;
        if (exp_zone(hc, ln) != 3) return 0;
        e = srow(hc, ln) - VDM - VOF;
        c = sidx(hc) - HDM - HOF;
        if (e % 2 == 0) return (c % 2 == 0) ? 2 : 3;
        return (c % 2 == 0) ? 1 : 2;
    endfunction

    function automatic logic [3:0] exp_v(input int hc, input int ln);
        if (ln == 0 || hc < 38 || hc >= 87) return 4'b1100;
        if (hc < 45) return 4'b1110;
        if (hc < 52) return 4'b0110;
        if (hc < 59) return 4'b0111;
        if (hc < 66) return 4'b0011;
        if (hc < 73) return 4'b1011;
        if (hc < 80) return 4'b1001;
        return 4'b1101;
    endfunction

    int sh_exp;
    int cnt_d, cnt_o, cnt_e;
    int last_hd, last_vd;
    logic [3:0] prev_v;
    logic prev_hd, prev_vd;

    task automatic check_cycle(input int n);
        int pix, ph, hc, ln, row, rk;
        bit ehd, evd, eh1, eh2, erg, etg1, etg3, eofd, eval;
        pix = n / 2; ph = n % 2; hc = pix % LP; ln = (pix / LP) % FL;
        ehd  = (hc < HSW);
        evd  = (ln == 0);
        eval = !idle(hc);
        eh1  = eval ? (ph == 0) : 1'b1;
        eh2  = !eh1;
        erg  = eval && (ph == 0);
        etg1 = (ln == 0) && hc >= 276 && hc < 338;
        etg3 = (ln == 0) && hc >= 319 && hc < 381;
        eofd = (ln != 0) && (ln < sh_exp) && hc >= 94 && hc < 101;
        chk(hd == ehd, "R1 hd", hd, ehd);
        chk(vd == evd, "R2 vd", vd, evd);
        chk({h1, h2, rg} == {eh1, eh2, erg}, "R3 h1/h2/rg", {h1, h2, rg}, {eh1, eh2, erg});
        chk(samp_valid == eval, "R4 valid", samp_valid, eval);
        chk(int'(samp_zone) == exp_zone(hc, ln), "R4/R5 zone", samp_zone, exp_zone(hc, ln));
        chk(int'(samp_color) == exp_color(hc, ln), "R6 color", samp_color, exp_color(hc, ln));
        chk({v1, v2, v3, v4} == exp_v(hc, ln), "R7 vphase", {v1, v2, v3, v4}, exp_v(hc, ln));
        chk({tg1, tg3} == {etg1, etg3}, "R8 transfer", {tg1, tg3}, {etg1, etg3});
        chk(ofd == eofd, "R9/R10 ofd", ofd, eofd);
        if (n > 0)
            chk(!(({v1, v2, v3, v4} != prev_v) && samp_valid), "R11 vedge", samp_valid, 0);
        if (hd && !prev_hd && n > 0) begin
            if (last_hd >= 0) chk(n - last_hd == CL, "R1 line period", n - last_hd, CL);
            last_hd = n;
        end
        if (vd && !prev_vd && n > 0) begin
            if (last_vd >= 0) chk(n - last_vd == FL * CL, "R2 frame period", n - last_vd, FL * CL);
            last_vd = n;
        end
        // per-row zone tallies, closed when the sample window ends
        if (hc == IS && ph == 0) begin
            if (n >= CL) begin
                row = srow(IS - 1, ln);
                rk  = span(row, VDM, VOF, VEF, VOR);
                if (rk == 0) begin
                    chk(cnt_d + cnt_o + cnt_e == 0, "R5 blank row", cnt_d + cnt_o + cnt_e, 0);
                end else if (rk == 1) begin
                    chk(cnt_d == 711, "R5 dummy row", cnt_d, 711);
                end else if (rk == 2) begin
                    chk(cnt_d == HDM && cnt_o == 695, "R5 black row", cnt_o, 695);
                end else begin
                    chk(cnt_d == HDM, "R4 dummy count", cnt_d, HDM);
                    chk(cnt_o == HOF + HOR, "R4 black count", cnt_o, HOF + HOR);
                    chk(cnt_e == HEF, "R4 effective count", cnt_e, HEF);
                end
            end
            cnt_d = 0; cnt_o = 0; cnt_e = 0;
        end
        if (samp_valid && ph == 0) begin
            if (samp_zone == 2'd1) cnt_d++;
            if (samp_zone == 2'd2) cnt_o++;
            if (samp_zone == 2'd3) cnt_e++;
        end
        prev_v  = {v1, v2, v3, v4};
        prev_hd = hd;
        prev_vd = vd;
    endtask

    initial begin
        int seed_v, n, val, chg, pix, hc, ln, ph;
        seed_v = $urandom(32'd7741);
        n = 0; last_hd = -1; last_vd = -1;
        cnt_d = 0; cnt_o = 0; cnt_e = 0;
        prev_v = '0; prev_hd = 1'b0; prev_vd = 1'b0;
        rst = 1'b1;
        shutter_line = 4'd5;
        sh_exp = 5;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < NFRAMES; f++) begin
            // directed: none (0), every line but last (FL-1), none (1); then random
            if (f == 0)      val = 0;
            else if (f == 1) val = FL - 1;
            else if (f == 2) val = 1;
            else             val = int'($urandom % FL);
            chg = 2 + int'($urandom % (FL - 4));
            for (int c = 0; c < FL * CL; c++) begin
                pix = n / 2; ph = n % 2; hc = pix % LP; ln = (pix / LP) % FL;
                if (n > 0 && ln == 0 && hc == 0 && ph == 0) sh_exp = int'(shutter_line);
                // R10: mid-frame change must not affect this frame
                if (ln == chg && hc == 200 && ph == 0) shutter_line = 4'(val);
                #1;
                check_cycle(n);
                n++;
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule